// File: doc/BRIEF.md
# Stereo DC Offset Remover with Freeze

This block removes the DC component from two channels of signed PCM audio that leave a decimation filter. Each channel carries a sample word and a one-cycle valid strobe. For every accepted sample the block subtracts a running estimate of the channel's DC level. The result is clamped to the sample range and presented one clock later together with its own valid strobe. The estimate is a first-order leaky integrator. It is kept with extra fractional bits and moves a fixed binary fraction of the way toward each new sample.

Each channel has two controls. The first turns the remover on or off; when it is off, samples pass through untouched. The second stops the estimate from learning while the held value is still subtracted. This lets a steady offset be removed during DC measurements without the tracking loop eating the signal. The controls come from the upper nibble of an 8-bit control word, which loads on a write strobe. The lower nibble belongs to neighbouring level-ramp logic and does not act here.

Top module: `dcr_stereo`

## Requirements
- R1: When a channel's enable bit is 0, its output equals the input sample exactly, one clock after the strobe.
- R2: After reset the control nibble is 4'b1010 (both channels enabled, neither frozen), both estimates are zero, and both outputs and output strobes are 0.
- R3: With enable 1, the output for a strobed sample x is sat(x - floor(E / 2^FRAC)). E is the channel's estimate before that sample's update, and the result appears one clock after the strobe.
- R4: With enable 1 and freeze 0, each strobed sample updates E to E + floor((x*2^FRAC - E) / 2^K), with K = 12 and FRAC = 12, so a constant input drives the output toward zero.
- R5: With freeze 1 and enable 1, E does not change, and the held E is still subtracted from every sample.
- R6: Clearing freeze resumes tracking from the held E, not from zero.
- R7: E changes only on a cycle whose strobe is high, and an output strobe is raised exactly one clock after each input strobe and at no other time.
- R8: Control bit 7 is B enable, bit 6 B freeze, bit 5 A enable, bit 4 A freeze. Each channel obeys only its own two bits, and bits 3..0 have no effect on either channel.
- R9: The subtraction saturates to [-2^23, 2^23-1] instead of wrapping.
- R10: While a channel is disabled its estimate is cleared to zero, so on re-enable the first output equals the input.
- R11: The control word changes only on a clock with the write strobe high, and the new value first governs samples in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word (bits 7..4 used) |
| a_pcm | input | 24 | Channel A signed sample |
| a_vld | input | 1 | Channel A sample strobe |
| b_pcm | input | 24 | Channel B signed sample |
| b_vld | input | 1 | Channel B sample strobe |
| a_out | output | 24 | Channel A offset-corrected sample |
| a_out_vld | output | 1 | Channel A output strobe |
| b_out | output | 24 | Channel B offset-corrected sample |
| b_out_vld | output | 1 | Channel B output strobe |

## Verification
Each corrected sample and its strobe are due one clock after the input strobe. A control write affects only samples strobed in the cycle after the write. The bench drives inputs on the falling edge and compares the outputs on the next falling edge against a per-channel integer model of the estimate. The model applies the pending control value only from the cycle after the write. Long constant runs push the estimate near full scale, so that a frozen channel fed the opposite extreme must clamp. Idle cycles between strobes confirm that nothing moves without a strobe.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   // number of audio channels handled by one instance
   localparam int unsigned DCR_CH        = 2;
   // per channel: {enable, freeze}
   localparam int unsigned DCR_MODE_W    = 2 * DCR_CH;
   // position of the mode nibble inside the 8-bit control word
   localparam int unsigned DCR_CTRL_W    = 8;
   localparam int unsigned DCR_MODE_LSB  = 4;
   // reset value of the mode nibble: {B en, B frz, A en, A frz}
   localparam logic [DCR_MODE_W-1:0] DCR_MODE_RST = 4'b1010;

   typedef struct packed {
      logic track_en;
      logic hold;
   } dcr_mode_t;

endpackage

// File: rtl/dcr_ctrl_reg.sv
module dcr_ctrl_reg #(
   parameter int unsigned   W   = 4,
   parameter logic [W-1:0]  RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("dcr_ctrl_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (wr) q <= d;
   end

   // R11: the word only moves on a write
   p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
   p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(d)));

endmodule

// File: rtl/dcr_tracker.sv
module dcr_tracker #(
   parameter int unsigned SW   = 24,
   parameter int unsigned K    = 12,
   parameter int unsigned FRAC = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 frz,
   input  logic                 vld,
   input  logic signed [SW-1:0] x,
   output logic signed [SW-1:0] est_int
);

   localparam int unsigned EW = SW + FRAC;

   if (SW < 2) begin : g_bad_sw
      $error("dcr_tracker: SW must be at least 2");
   end
   if (K < 1) begin : g_bad_k
      $error("dcr_tracker: K must be at least 1");
   end

   logic signed [EW-1:0] est_q;
   logic signed [EW-1:0] est_d;
   logic signed [EW:0]   x_ext;
   logic signed [EW:0]   est_ext;
   logic signed [EW:0]   gap;

   always_comb begin
      x_ext   = (EW+1)'(x) <<< FRAC;
      est_ext = (EW+1)'(est_q);
      gap     = x_ext - est_ext;
      est_d   = est_q;
      if (!en)
         est_d = '0;
      else if (vld && !frz)
         est_d = est_q + EW'(gap >>> K);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) est_q <= '0;
      else        est_q <= est_d;
   end

   // integer part of the estimate: a plain slice or the whole word
   if (FRAC == 0) begin : g_no_frac
      assign est_int = est_q;
   end else begin : g_frac
      assign est_int = est_q[EW-1:FRAC];
   end

   // R5: a frozen estimate does not move
   p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && frz) |=> $stable(est_q));
   // R7: no strobe, no learning
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !vld) |=> $stable(est_q));
   // R10: disabled channel forgets its offset
   p_clear_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (est_q == '0));
   // R4: the estimate never moves away from the sample
   p_move_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !frz && vld && (x_ext >= est_ext)) |=> (est_q >= $past(est_q)));
   p_move_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !frz && vld && (x_ext <= est_ext)) |=> (est_q <= $past(est_q)));

endmodule

// File: rtl/dcr_trim_sub.sv
module dcr_trim_sub #(
   parameter int unsigned SW       = 24,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 vld,
   input  logic signed [SW-1:0] x,
   input  logic signed [SW-1:0] est_int,
   output logic signed [SW-1:0] y,
   output logic                 y_vld
);

   localparam logic signed [SW-1:0] PMAX = {1'b0, {(SW-1){1'b1}}};
   localparam logic signed [SW-1:0] PMIN = {1'b1, {(SW-1){1'b0}}};

   if (SW < 2) begin : g_bad_sw
      $error("dcr_trim_sub: SW must be at least 2");
   end

   logic signed [SW:0]   diff;
   logic signed [SW-1:0] trimmed;
   logic signed [SW-1:0] y_d;

   assign diff = (SW+1)'(x) - (SW+1)'(est_int);

   if (SATURATE) begin : g_sat
      always_comb begin
         if (diff[SW] != diff[SW-1]) trimmed = diff[SW] ? PMIN : PMAX;
         else                        trimmed = diff[SW-1:0];
      end

      // R9: no sign flip when the true difference leaves the range
      p_no_wrap_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (vld && en && !x[SW-1] && est_int[SW-1]) |=> !y[SW-1]);
      p_no_wrap_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (vld && en && x[SW-1] && !est_int[SW-1]) |=> y[SW-1]);
   end else begin : g_wrap
      assign trimmed = diff[SW-1:0];
   end

   assign y_d = en ? trimmed : x;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y     <= '0;
         y_vld <= 1'b0;
      end else begin
         y_vld <= vld;
         if (vld) y <= y_d;
      end
   end

   // R1: bypass is bit-exact
   p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (vld && !en) |=> (y == $past(x)));
   // R7: output strobe follows input strobe by one clock
   p_vld_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vld |=> y_vld);
   p_vld_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vld |=> !y_vld);

endmodule

// File: rtl/dcr_stereo.sv
module dcr_stereo #(
   parameter int unsigned SW       = 24,
   parameter int unsigned K        = 12,
   parameter int unsigned FRAC     = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_wr,
   input  logic [7:0]           ctrl_wdata,
   input  logic signed [SW-1:0] a_pcm,
   input  logic                 a_vld,
   input  logic signed [SW-1:0] b_pcm,
   input  logic                 b_vld,
   output logic signed [SW-1:0] a_out,
   output logic                 a_out_vld,
   output logic signed [SW-1:0] b_out,
   output logic                 b_out_vld
);
   import dcr_pkg::*;

   localparam int unsigned NCH = DCR_CH;

   if (DCR_MODE_LSB + DCR_MODE_W > DCR_CTRL_W) begin : g_bad_map
      $error("dcr_stereo: mode field does not fit in the control word");
   end

   logic [DCR_MODE_W-1:0] mode_q;

   dcr_ctrl_reg #(
      .W   (DCR_MODE_W),
      .RST (DCR_MODE_RST)
   ) i_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr),
      .d     (ctrl_wdata[DCR_MODE_LSB +: DCR_MODE_W]),
      .q     (mode_q)
   );

   logic signed [SW-1:0] pcm_in  [NCH];
   logic                 vld_in  [NCH];
   logic signed [SW-1:0] pcm_out [NCH];
   logic                 vld_out [NCH];

   assign pcm_in[0] = a_pcm;
   assign vld_in[0] = a_vld;
   assign pcm_in[1] = b_pcm;
   assign vld_in[1] = b_vld;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dcr_mode_t            mode;
      logic signed [SW-1:0] est_int;

      assign mode.track_en = mode_q[2*c+1];
      assign mode.hold     = mode_q[2*c];

      dcr_tracker #(
         .SW   (SW),
         .K    (K),
         .FRAC (FRAC)
      ) i_track (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (mode.track_en),
         .frz     (mode.hold),
         .vld     (vld_in[c]),
         .x       (pcm_in[c]),
         .est_int (est_int)
      );

      dcr_trim_sub #(
         .SW       (SW),
         .SATURATE (SATURATE)
      ) i_sub (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (mode.track_en),
         .vld     (vld_in[c]),
         .x       (pcm_in[c]),
         .est_int (est_int),
         .y       (pcm_out[c]),
         .y_vld   (vld_out[c])
      );
   end

   assign a_out     = pcm_out[0];
   assign a_out_vld = vld_out[0];
   assign b_out     = pcm_out[1];
   assign b_out_vld = vld_out[1];

   // R8: a write with an unchanged mode nibble leaves both channels' modes alone
   p_mode_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && (ctrl_wdata[DCR_MODE_LSB +: DCR_MODE_W] == mode_q)) |=> $stable(mode_q));

endmodule

// File: tb/test_dcr_stereo.sv
module test_dcr_stereo;

   localparam int SW = 24;
   localparam int K  = 12;
   localparam int F  = 12;
   localparam longint PMAX = (64'sd1 <<< (SW-1)) - 1;
   localparam longint PMIN = -(64'sd1 <<< (SW-1));

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic                 ctrl_wr = 1'b0;
   logic [7:0]           ctrl_wdata = 8'h00;
   logic signed [SW-1:0] a_pcm = '0, b_pcm = '0;
   logic                 a_vld = 1'b0, b_vld = 1'b0;
   logic signed [SW-1:0] a_out, b_out;
   logic                 a_out_vld, b_out_vld;

   int n_tests = 0;
   int n_fail  = 0;

   longint     est_m [2];
   logic [7:0] ctl_m = 8'hA0;

   dcr_stereo i_dcr_stereo (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .a_pcm(a_pcm), .a_vld(a_vld), .b_pcm(b_pcm), .b_vld(b_vld),
      .a_out(a_out), .a_out_vld(a_out_vld), .b_out(b_out), .b_out_vld(b_out_vld)
   );

   function automatic longint sat(input longint v);
      if (v > PMAX) return PMAX;
      if (v < PMIN) return PMIN;
      return v;
   endfunction

   // channel model built from R3, R4, R5, R10
   function automatic longint model(input int c, input longint x);
      longint y;
      logic en, frz;
      en  = ctl_m[5 + 2*c];
      frz = ctl_m[4 + 2*c];
      if (!en) begin
         est_m[c] = 0;
         return x;
      end
      y = sat(x - (est_m[c] >>> F));
      if (!frz) est_m[c] = est_m[c] + (((x <<< F) - est_m[c]) >>> K);
      return y;
   endfunction

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(input bit va, input longint xa, input bit vb, input longint xb,
                       input bit chk, input string req);
      longint ea, eb;
      ea = va ? model(0, xa) : 0;
      eb = vb ? model(1, xb) : 0;
      a_vld = va; a_pcm = xa[SW-1:0];
      b_vld = vb; b_pcm = xb[SW-1:0];
      @(negedge clk);
      a_vld = 1'b0; b_vld = 1'b0;
      if (chk) begin
         check(req, "a_out_vld", longint'(a_out_vld), longint'(va));
         check(req, "b_out_vld", longint'(b_out_vld), longint'(vb));
         if (va) check(req, "a_out", longint'(a_out), ea);
         if (vb) check(req, "b_out", longint'(b_out), eb);
      end
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctrl_wdata = v; ctrl_wr = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0;
      ctl_m = v;
      if (!v[5]) est_m[0] = 0;
      if (!v[7]) est_m[1] = 0;
   endtask

   task automatic t_reset;
      check("R2", "a_out_vld after reset", longint'(a_out_vld), 0);
      check("R2", "b_out_vld after reset", longint'(b_out_vld), 0);
      check("R2", "a_out after reset", longint'(a_out), 0);
      check("R2", "b_out after reset", longint'(b_out), 0);
      // zero estimate: first sample passes unchanged while filtering is on
      step(1, 1234, 1, -777, 1, "R2");
      check("R2", "first A output equals input", longint'(a_out), 1234);
   endtask

   task automatic t_track;
      for (int i = 0; i < 300; i++) step(1, 100000, 1, -50000, 1, "R4");
      // R3/R4: after ~300/4096 of a time constant output has shrunk noticeably
      n_tests++;
      if (!(a_out < 100000 && a_out > 0)) begin
         n_fail++;
         $display("FAIL R4 a_out decay: actual %0d expected within (0,100000)", a_out);
      end
      for (int i = 0; i < 20; i++) step(1, (i % 2) ? 4000 : -3000, 1, i * 37, 1, "R3");
   endtask

   task automatic t_idle;
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R7");
      step(1, 55555, 0, 0, 1, "R7");
      step(0, 0, 1, -222, 1, "R7");
   endtask

   task automatic t_freeze;
      longint first;
      write_ctl(8'hB0); // A frozen, B tracking (R8)
      step(1, 70000, 1, 9000, 1, "R5");
      first = longint'(a_out);
      for (int i = 0; i < 50; i++) step(1, 70000, 1, 9000, 1, "R5");
      check("R5", "frozen A output constant", longint'(a_out), first);
      step(1, -20000, 1, 1, 1, "R5");
   endtask

   task automatic t_release;
      write_ctl(8'hA0);
      for (int i = 0; i < 40; i++) step(1, 70000, 1, 9000, 1, "R6");
   endtask

   task automatic t_bypass;
      write_ctl(8'h80); // A off, B on
      step(1, -123456, 1, 3333, 1, "R1");
      check("R1", "bypass A exact", longint'(a_out), -123456);
      step(1, PMAX, 1, 0, 1, "R1");
      check("R1", "bypass A max", longint'(a_out), PMAX);
      write_ctl(8'hA0);
      step(1, 4242, 1, 0, 1, "R10");
      check("R10", "re-enabled A starts from zero", longint'(a_out), 4242);
   endtask

   task automatic t_ignore_bits;
      write_ctl(8'hAF); // lower nibble set: no effect (R8)
      for (int i = 0; i < 10; i++) step(1, 800 + i, 1, -800 - i, 1, "R8");
      ctrl_wdata = 8'h00; // no strobe: must not disable (R11)
      for (int i = 0; i < 10; i++) step(1, 8000, 1, -8000, 1, "R11");
      write_ctl(8'h20); // B off, A on
      step(1, 500, 1, -987654, 1, "R8");
      check("R8", "B bypass only", longint'(b_out), -987654);
      write_ctl(8'hA0);
   endtask

   task automatic t_sat;
      for (int i = 0; i < 12000; i++) step(1, PMIN, 1, PMAX, 0, "R9");
      step(1, PMIN, 1, PMAX, 1, "R9");
      write_ctl(8'hF0); // both frozen near full scale
      step(1, PMAX, 1, PMIN, 1, "R9");
      check("R9", "A clamps high", longint'(a_out), PMAX);
      check("R9", "B clamps low", longint'(b_out), PMIN);
      step(1, 0, 1, 0, 1, "R9");
      write_ctl(8'hA0);
   endtask

   initial begin
      est_m[0] = 0; est_m[1] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_track();
      t_idle();
      t_freeze();
      t_release();
      t_bypass();
      t_ignore_bits();
      t_sat();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule